// File: doc/BRIEF.md
# Boundary-Scan Instruction Register and Decoder

This block holds the 8-bit instruction register of a boundary-scan test port, the decoder that turns the active opcode into controls for the boundary cells, and the single-stage bypass register. It is driven by the state strobes of an external TAP state machine (Test-Logic-Reset, Capture/Shift/Update-IR and Capture/Shift-DR), by the test clock, by the serial test input and by the scan output of the boundary chain. The block returns a mode select for the boundary cells, a force-high-impedance control, a data-register select and the serial test output with its enable.

The device has no identification register. The value loaded on Capture-IR therefore acts as a device-specific marker. Its two low bits `01` are the pattern the standard requires. Besides the mandatory instructions, the decoder implements an output clamp and a global high-impedance instruction. Both of these route the data path through the bypass stage.

Top module: `jtag_ir_ctrl`

## Requirements
- R1: After the asynchronous reset `trst_n`, the active instruction is all ones (bypass), `bsr_mode`, `force_hiz`, `sel_bsr`, `tdo` and `tdo_oe` are all 0.
- R2: A rising `tck` edge with `capture_ir` high loads 8'b1000_0001 into the instruction shift stage. Capture takes priority over shift.
- R3: A rising `tck` edge with `shift_ir` high moves the shift stage one place toward bit 0 and puts `tdi` into bit 7, so bit 0 leaves first. During shifting the active instruction and the decoded outputs do not change.
- R4: A falling `tck` edge with `update_ir` high copies the shift stage into the active instruction. The decoded outputs change on that same edge.
- R5: Opcode 8'h00 (external test) gives `bsr_mode`=1, `sel_bsr`=1, `force_hiz`=0.
- R6: Opcode 8'h81 (sample/preload) gives `bsr_mode`=0, `sel_bsr`=1, `force_hiz`=0.
- R7: Opcode 8'h82 (clamp) gives `bsr_mode`=1, `sel_bsr`=0, `force_hiz`=0.
- R8: Opcode 8'h03 (high impedance) gives `force_hiz`=1, `bsr_mode`=0, `sel_bsr`=0.
- R9: Every other opcode behaves as bypass and sets all three control outputs to 0.
- R10: The bypass stage loads 0 on a rising edge with `capture_dr` high and loads `tdi` on a rising edge with `shift_dr` high. When `sel_bsr`=0, Shift-DR presents it on `tdo`.
- R11: In Shift-DR with `sel_bsr`=1, `tdo` takes the value of `bsr_so` at the falling edge.
- R12: `tdo` and `tdo_oe` change only on falling `tck` edges. `tdo_oe` is 1 exactly after a falling edge at which `shift_ir` or `shift_dr` was high. Outside shifting, `tdo` holds its last value.
- R13: A falling edge with `tlr` high makes bypass (all ones) the active instruction. This overrides `update_ir` and returns all control outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset, released synchronously to `tck` |
| tlr | input | 1 | TAP in Test-Logic-Reset |
| capture_ir | input | 1 | TAP in Capture-IR |
| shift_ir | input | 1 | TAP in Shift-IR |
| update_ir | input | 1 | TAP in Update-IR |
| capture_dr | input | 1 | TAP in Capture-DR |
| shift_dr | input | 1 | TAP in Shift-DR |
| tdi | input | 1 | Serial test data in |
| bsr_so | input | 1 | Scan output of the boundary chain |
| bsr_mode | output | 1 | 1: boundary update latches drive pins and enables |
| force_hiz | output | 1 | 1: all data outputs forced to high impedance |
| sel_bsr | output | 1 | Data register select: 1 boundary chain, 0 bypass |
| tdo | output | 1 | Serial test data out |
| tdo_oe | output | 1 | Output enable for `tdo` |

## Verification
The hardest situation to reach is a collision between `tlr` and `update_ir` at the same falling edge, because a real TAP never produces it. The bench drives the strobes directly, so it can raise both together right after it has shifted in a non-bypass opcode. The same freedom lets it shift opcodes that differ in a single bit from the implemented ones (8'h01, 8'h80, 8'h83). This exposes decoders that compare too few bits. A behavioural model runs alongside and compares every output once per cycle, after the falling edge.

// File: rtl/jtag_ir_pkg.sv
package jtag_ir_pkg;

  // decoded controls handed to the boundary cells and the TDO path
  typedef struct packed {
    logic bsr_mode;
    logic force_hiz;
    logic sel_bsr;
  } ir_ctl_t;

  localparam ir_ctl_t CTL_IDLE = '{bsr_mode: 1'b0, force_hiz: 1'b0, sel_bsr: 1'b0};

endpackage

// File: rtl/jtag_rst_sync.sv
module jtag_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/jtag_ir_shift.sv
module jtag_ir_shift #(
  parameter int            W    = 8,
  parameter logic [W-1:0]  CAPT = 8'b1000_0001
) (
  input  logic         tck,
  input  logic         rst_n,
  input  logic         capture_ir,
  input  logic         shift_ir,
  input  logic         tdi,
  output logic [W-1:0] sr_q
);

  logic [W-1:0] sr_d;
  logic         sr_en;

  always_comb begin
    sr_en = capture_ir | shift_ir;
    if (capture_ir) sr_d = CAPT;
    else            sr_d = {tdi, sr_q[W-1:1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     sr_q <= CAPT;
    else if (sr_en) sr_q <= sr_d;
  end

  // R2: capture always lands the fixed marker value
  p_capture_marker_r2: assert property (@(posedge tck) disable iff (!rst_n)
    capture_ir |=> (sr_q == CAPT));

  // R3: lowest bit leaves, tdi enters at the top
  p_shift_entry_r3: assert property (@(posedge tck) disable iff (!rst_n)
    (shift_ir && !capture_ir) |=> (sr_q[W-1] == $past(tdi)));

endmodule

// File: rtl/jtag_ir_hold.sv
module jtag_ir_hold
  import jtag_ir_pkg::*;
#(
  parameter int           W          = 8,
  parameter logic [W-1:0] OP_RESET   = 8'hFF,
  parameter logic [W-1:0] OP_EXTEST  = 8'h00,
  parameter logic [W-1:0] OP_SAMPLE  = 8'h81,
  parameter logic [W-1:0] OP_CLAMP   = 8'h82,
  parameter logic [W-1:0] OP_HIGHZ   = 8'h03
) (
  input  logic         tck,
  input  logic         rst_n,
  input  logic         tlr,
  input  logic         update_ir,
  input  logic [W-1:0] sr_d,
  output logic [W-1:0] instr_q,
  output ir_ctl_t      ctl_q
);

  logic [W-1:0] instr_d;
  ir_ctl_t      ctl_d;
  logic         hold_en;

  always_comb begin
    hold_en = tlr | update_ir;
    if (tlr) instr_d = OP_RESET;
    else     instr_d = sr_d;
  end

  always_comb begin
    ctl_d = CTL_IDLE;
    if (instr_d == OP_EXTEST) begin
      ctl_d.bsr_mode = 1'b1;
      ctl_d.sel_bsr  = 1'b1;
    end else if (instr_d == OP_SAMPLE) begin
      ctl_d.sel_bsr  = 1'b1;
    end else if (instr_d == OP_CLAMP) begin
      ctl_d.bsr_mode = 1'b1;
    end else if (instr_d == OP_HIGHZ) begin
      ctl_d.force_hiz = 1'b1;
    end
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      instr_q <= OP_RESET;
      ctl_q   <= CTL_IDLE;
    end else if (hold_en) begin
      instr_q <= instr_d;
      ctl_q   <= ctl_d;
    end
  end

  // R3: without update or reset strobe the active instruction is frozen
  p_instr_frozen_r3: assert property (@(posedge tck) disable iff (!rst_n)
    ($past(rst_n) && !tlr && !update_ir) |-> $stable(instr_q));

  // R4: update copies the shift stage held across the falling edge
  p_update_copy_r4: assert property (@(posedge tck) disable iff (!rst_n)
    ($past(rst_n) && update_ir && !tlr) |-> (instr_q == sr_d));

endmodule

// File: rtl/jtag_bypass_cell.sv
module jtag_bypass_cell (
  input  logic tck,
  input  logic rst_n,
  input  logic capture_dr,
  input  logic shift_dr,
  input  logic tdi,
  output logic byp_q
);

  logic byp_d;
  logic byp_en;

  always_comb begin
    byp_en = capture_dr | shift_dr;
    byp_d  = capture_dr ? 1'b0 : tdi;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      byp_q <= 1'b0;
    else if (byp_en) byp_q <= byp_d;
  end

  // R10: capture loads a constant low
  p_bypass_zero_r10: assert property (@(posedge tck) disable iff (!rst_n)
    capture_dr |=> !byp_q);

endmodule

// File: rtl/jtag_tdo_stage.sv
module jtag_tdo_stage (
  input  logic tck,
  input  logic rst_n,
  input  logic shift_ir,
  input  logic shift_dr,
  input  logic sel_bsr,
  input  logic ir_lsb,
  input  logic bsr_so,
  input  logic byp,
  output logic tdo,
  output logic tdo_oe
);

  logic tdo_d;
  logic tdo_en;
  logic dr_bit;

  always_comb begin
    dr_bit = sel_bsr ? bsr_so : byp;
    tdo_en = shift_ir | shift_dr;
    tdo_d  = shift_ir ? ir_lsb : dr_bit;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= tdo_en;
      if (tdo_en) tdo <= tdo_d;
    end
  end

  // R12: enable follows the shift strobes one falling edge later
  p_oe_follows_shift_r12: assert property (@(posedge tck) disable iff (!rst_n)
    $past(rst_n) |-> (tdo_oe == (shift_ir || shift_dr)));

  // R12: no shifting, no change on tdo
  p_tdo_hold_r12: assert property (@(posedge tck) disable iff (!rst_n)
    ($past(rst_n) && !shift_ir && !shift_dr) |-> $stable(tdo));

endmodule

// File: rtl/jtag_ir_ctrl.sv
module jtag_ir_ctrl
  import jtag_ir_pkg::*;
#(
  parameter int           IR_W      = 8,
  parameter logic [IR_W-1:0] IR_CAPT   = 8'b1000_0001,
  parameter logic [IR_W-1:0] OP_BYPASS = 8'hFF,
  parameter logic [IR_W-1:0] OP_EXTEST = 8'h00,
  parameter logic [IR_W-1:0] OP_SAMPLE = 8'h81,
  parameter logic [IR_W-1:0] OP_CLAMP  = 8'h82,
  parameter logic [IR_W-1:0] OP_HIGHZ  = 8'h03,
  parameter int           SYNC_STAGES = 2
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tlr,
  input  logic capture_ir,
  input  logic shift_ir,
  input  logic update_ir,
  input  logic capture_dr,
  input  logic shift_dr,
  input  logic tdi,
  input  logic bsr_so,
  output logic bsr_mode,
  output logic force_hiz,
  output logic sel_bsr,
  output logic tdo,
  output logic tdo_oe
);

  logic            rst_n_s;
  logic [IR_W-1:0] ir_sr;
  logic [IR_W-1:0] ir_act;
  ir_ctl_t         ctl;
  logic            byp;

  jtag_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (tck),
    .arst_n  (trst_n),
    .rst_n_o (rst_n_s)
  );

  jtag_ir_shift #(.W(IR_W), .CAPT(IR_CAPT)) u_shift (
    .tck        (tck),
    .rst_n      (rst_n_s),
    .capture_ir (capture_ir),
    .shift_ir   (shift_ir),
    .tdi        (tdi),
    .sr_q       (ir_sr)
  );

  jtag_ir_hold #(
    .W(IR_W), .OP_RESET(OP_BYPASS), .OP_EXTEST(OP_EXTEST),
    .OP_SAMPLE(OP_SAMPLE), .OP_CLAMP(OP_CLAMP), .OP_HIGHZ(OP_HIGHZ)
  ) u_hold (
    .tck       (tck),
    .rst_n     (rst_n_s),
    .tlr       (tlr),
    .update_ir (update_ir),
    .sr_d      (ir_sr),
    .instr_q   (ir_act),
    .ctl_q     (ctl)
  );

  jtag_bypass_cell u_byp (
    .tck        (tck),
    .rst_n      (rst_n_s),
    .capture_dr (capture_dr),
    .shift_dr   (shift_dr),
    .tdi        (tdi),
    .byp_q      (byp)
  );

  jtag_tdo_stage u_tdo (
    .tck      (tck),
    .rst_n    (rst_n_s),
    .shift_ir (shift_ir),
    .shift_dr (shift_dr),
    .sel_bsr  (ctl.sel_bsr),
    .ir_lsb   (ir_sr[0]),
    .bsr_so   (bsr_so),
    .byp      (byp),
    .tdo      (tdo),
    .tdo_oe   (tdo_oe)
  );

  assign bsr_mode  = ctl.bsr_mode;
  assign force_hiz = ctl.force_hiz;
  assign sel_bsr   = ctl.sel_bsr;

  // R13: test-logic-reset at the falling edge leaves bypass active
  p_tlr_bypass_r13: assert property (@(posedge tck) disable iff (!rst_n_s)
    ($past(rst_n_s) && tlr) |-> (ir_act == OP_BYPASS && !bsr_mode && !force_hiz && !sel_bsr));

  // R8: high impedance never coexists with a boundary-chain path
  p_hiz_exclusive_r8: assert property (@(posedge tck) disable iff (!rst_n_s)
    force_hiz |-> (!sel_bsr && !bsr_mode));

  // R9: the bypass code keeps every control low
  p_bypass_quiet_r9: assert property (@(posedge tck) disable iff (!rst_n_s)
    (ir_act == OP_BYPASS) |-> !(bsr_mode || force_hiz || sel_bsr));

endmodule

// File: tb/sim_jtag_ir_ctrl.sv
module sim_jtag_ir_ctrl;

  localparam int CLK_PERIOD = 20;

  logic tck = 1'b0;
  logic trst_n, tlr, capture_ir, shift_ir, update_ir, capture_dr, shift_dr, tdi, bsr_so;
  logic bsr_mode, force_hiz, sel_bsr, tdo, tdo_oe;

  int vectors = 0;
  int miscompares = 0;

  // reference model state
  logic [7:0] m_ir, m_instr;
  logic       m_byp, m_tdo, m_oe;

  always #(CLK_PERIOD/2) tck = ~tck;

  jtag_ir_ctrl u0 (
    .tck(tck), .trst_n(trst_n), .tlr(tlr), .capture_ir(capture_ir),
    .shift_ir(shift_ir), .update_ir(update_ir), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .tdi(tdi), .bsr_so(bsr_so), .bsr_mode(bsr_mode),
    .force_hiz(force_hiz), .sel_bsr(sel_bsr), .tdo(tdo), .tdo_oe(tdo_oe)
  );

  // expected {mode, hiz, sel} for an opcode
  function automatic logic [2:0] expect_ctl(input logic [7:0] op);
    case (op)
      8'h00:   return 3'b101;
      8'h81:   return 3'b001;
      8'h82:   return 3'b100;
      8'h03:   return 3'b010;
      default: return 3'b000;
    endcase
  endfunction

  task automatic step(input logic tl, input logic cir, input logic sir, input logic uir,
                      input logic cdr, input logic sdr, input logic td, input logic bso,
                      input string req);
    logic [2:0] old_ctl, exp_ctl;
    @(posedge tck);
    #(CLK_PERIOD/4);
    tlr = tl; capture_ir = cir; shift_ir = sir; update_ir = uir;
    capture_dr = cdr; shift_dr = sdr; tdi = td; bsr_so = bso;
    // falling-edge behaviour
    old_ctl = expect_ctl(m_instr);
    if (sir)      m_tdo = m_ir[0];
    else if (sdr) m_tdo = old_ctl[0] ? bso : m_byp;
    m_oe = sir | sdr;
    if (tl)       m_instr = 8'hFF;
    else if (uir) m_instr = m_ir;
    exp_ctl = expect_ctl(m_instr);
    @(negedge tck);
    #(CLK_PERIOD/4);
    vectors++;
    if ({bsr_mode, force_hiz, sel_bsr} !== exp_ctl || tdo !== m_tdo || tdo_oe !== m_oe) begin
      miscompares++;
      $display("FAIL %s: {mode,hiz,sel,tdo,oe} actual %b%b%b%b%b expected %b%b%b%b%b",
               req, bsr_mode, force_hiz, sel_bsr, tdo, tdo_oe,
               exp_ctl[2], exp_ctl[1], exp_ctl[0], m_tdo, m_oe);
    end
    // rising-edge behaviour
    if (cir)      m_ir = 8'h81;
    else if (sir) m_ir = {td, m_ir[7:1]};
    if (cdr)      m_byp = 1'b0;
    else if (sdr) m_byp = td;
  endtask

  task automatic idle(input string req);
    step(0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask

  // capture, shift code in LSB first, update
  task automatic load_ir(input logic [7:0] code, input string req);
    step(0, 1, 0, 0, 0, 0, 0, 0, "R2");
    for (int i = 0; i < 8; i++) step(0, 0, 1, 0, 0, 0, code[i], 0, "R3");
    step(0, 0, 0, 1, 0, 0, 0, 0, "R4");
    idle(req);
  endtask

  task automatic shift_dr_bits(input logic [7:0] din, input logic [7:0] so, input string req);
    step(0, 0, 0, 0, 1, 0, 0, 0, req);
    for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0, 1, din[i], so[i], req);
    idle(req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    trst_n = 1'b0; tlr = 0; capture_ir = 0; shift_ir = 0; update_ir = 0;
    capture_dr = 0; shift_dr = 0; tdi = 0; bsr_so = 0;
    m_ir = 8'h81; m_instr = 8'hFF; m_byp = 0; m_tdo = 0; m_oe = 0;
    repeat (3) @(posedge tck);
    #(CLK_PERIOD/4);
    trst_n = 1'b1;
    repeat (4) idle("R1");

    // R2 marker shifted out while loading R5 external test
    load_ir(8'h00, "R5");
    shift_dr_bits(8'hA5, 8'h3C, "R11");
    load_ir(8'h81, "R6");
    shift_dr_bits(8'h0F, 8'hC9, "R11");
    load_ir(8'h82, "R7");
    shift_dr_bits(8'h6B, 8'hFF, "R10");
    load_ir(8'h03, "R8");
    shift_dr_bits(8'hD2, 8'h00, "R10");
    // near-miss and arbitrary opcodes fall back to bypass
    load_ir(8'h01, "R9");
    load_ir(8'h80, "R9");
    load_ir(8'h83, "R9");
    load_ir(8'h55, "R9");
    shift_dr_bits(8'h96, 8'h5A, "R10");
    load_ir(8'hFF, "R9");
    // R12 tdo holds while idle after a shift
    repeat (3) idle("R12");

    // R13 reset strobe wins over a simultaneous update
    load_ir(8'h00, "R5");
    step(0, 1, 0, 0, 0, 0, 0, 0, "R2");
    for (int i = 0; i < 8; i++) step(0, 0, 1, 0, 0, 0, 1'b0, 0, "R3");
    step(1, 0, 0, 1, 0, 0, 0, 0, "R13");
    idle("R13");
    // plain reset strobe out of clamp
    load_ir(8'h82, "R7");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R13");
    idle("R13");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule